// File: doc/BRIEF.md
# Interval Alarm Timer

This block is an 8-bit interval timer that sits beside a real-time clock chain. The clock chain supplies four single-cycle rate strobes: 1/128 second, second, minute and hour. A two-bit selector chooses which strobe the timer counts. When the number of counted ticks reaches a programmed interval, the timer raises a sticky alarm flag and emits a one-cycle interrupt pulse.

A mode input picks between two kinds of operation. In one kind the timer restarts by itself after every alarm. In the other it fires once and then stays idle until its enable is cleared and set again. The timer advances only while its own enable and the global clock enable are both high. Clearing the timer enable returns its counter to zero. Software can clear the alarm flag with a strobe, but it has no means of setting the flag.

Top module: `interval_alarm_timer`

## Requirements
- R1: `base_sel` picks the counted strobe: 2'b00 the 1/128 s strobe, 2'b01 the second strobe, 2'b10 the minute strobe, 2'b11 the hour strobe. Strobes that are not selected have no effect on `tick_count`, `alarm_flag` or `alarm_irq`.
- R2: While `tmr_en` and `rtc_en` are both 1 and the timer is not stopped, each cycle with the selected strobe high adds one to `tick_count`, and the result appears after that clock edge.
- R3: A cycle with `tmr_en` at 0 makes `tick_count` 0 after the edge and counts nothing. It also re-arms a one-shot timer that has stopped.
- R4: While `rtc_en` is 0, `tick_count` holds its value and no alarm occurs, even when the selected strobe is high.
- R5: When a counted tick brings the count to the interval value, `tick_count` returns to 0 and `alarm_flag` is set after that edge. An `interval` of 0 stands for 256 ticks.
- R6: With `one_shot` at 1, the timer stops after its first alarm: `tick_count` stays at 0 and no further alarm occurs until `tmr_en` is cleared. With `one_shot` at 0, counting goes on and an alarm occurs after every interval.
- R7: `flag_clr` high clears `alarm_flag` after the edge. If an alarm occurs in the same cycle, the flag ends up set. `alarm_irq` is high for exactly the one cycle after each alarm, and `alarm_flag` is high during that cycle.
- R8: After reset, `tick_count` is 0, and `alarm_flag` and `alarm_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_frac | input | 1 | 1/128 s strobe, one cycle wide |
| stb_sec | input | 1 | Second strobe, one cycle wide |
| stb_min | input | 1 | Minute strobe, one cycle wide |
| stb_hour | input | 1 | Hour strobe, one cycle wide |
| base_sel | input | 2 | Time-base selector |
| one_shot | input | 1 | 1: single alarm, 0: auto-restart |
| tmr_en | input | 1 | Timer enable; 0 clears the counter |
| rtc_en | input | 1 | Global clock-chain enable |
| interval | input | 8 | Ticks per interval (0 means 256) |
| flag_clr | input | 1 | Alarm-flag clear strobe |
| tick_count | output | 8 | Present counter value |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | One-cycle interrupt pulse per alarm |

## Verification
The hardest case to reach is an alarm and a clear that land on the same edge. For the same-edge case to matter, the flag must already be set from an earlier alarm. The bench asserts `flag_clr` on every third strobe of every sweep, and it includes the intervals 1 and 3. This makes clears collide with alarms that come straight after set flags. The other hard case is the 256-tick interval. Its counter passes 255, and the bench reaches it by sweeping the full 512 strobes for every base and mode.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  localparam int TMR_W     = 8;
  localparam int NUM_BASES = 4;
  localparam int SEL_W     = $clog2(NUM_BASES);

  typedef enum logic [SEL_W-1:0] {
    BASE_FRAC = 2'd0,
    BASE_SEC  = 2'd1,
    BASE_MIN  = 2'd2,
    BASE_HOUR = 2'd3
  } base_e;

endpackage

// File: rtl/itmr_base_mux.sv
module itmr_base_mux
  import itmr_pkg::*;
#(
  parameter int N_BASE = NUM_BASES,
  parameter int S_W    = SEL_W
) (
  input  logic [N_BASE-1:0] strobes,
  input  logic [S_W-1:0]    sel,
  output logic              tick
);

  logic [N_BASE-1:0] picked;

  for (genvar g = 0; g < N_BASE; g++) begin : g_pick
    assign picked[g] = strobes[g] & (sel == S_W'(g));
  end

  assign tick = |picked;

  always_comb begin
    assert ($onehot0(picked)); // R1 at most one base taken
  end

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = itmr_pkg::TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tmr_en,
  input  logic             rtc_en,
  input  logic             one_shot,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] count,
  output logic             fire,
  output logic             stopped
);

  localparam int EXT_W = CNT_W + 1;

  function automatic logic [EXT_W-1:0] span_of(input logic [CNT_W-1:0] iv);
    return (iv == '0) ? EXT_W'(1) << CNT_W : EXT_W'(iv);
  endfunction

  function automatic logic [EXT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return EXT_W'(c) + EXT_W'(1);
  endfunction

  logic             running;
  logic             step;
  logic [EXT_W-1:0] nxt;
  logic [EXT_W-1:0] span;

  assign running = tmr_en & rtc_en & ~stopped;
  assign step    = running & tick;
  assign nxt     = bump(count);
  assign span    = span_of(interval);
  assign fire    = step & (nxt == span);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      stopped <= 1'b0;
    end else if (!tmr_en) begin
      count   <= '0;
      stopped <= 1'b0;
    end else if (fire) begin
      count   <= '0;
      stopped <= one_shot;
    end else if (step) begin
      count   <= nxt[CNT_W-1:0];
    end
  end

  AST_CLEAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> (count == '0)); // R3

  AST_HOLD_NO_RTC: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && !rtc_en) |=> $stable(count)); // R4

  AST_ONESHOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && tmr_en) |=> (count == '0) && !fire); // R6

  AST_FIRE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && tmr_en) |=> (count == '0)); // R5

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fire && tmr_en) |=> (count == $past(count) + CNT_W'(1))); // R2

endmodule

// File: rtl/itmr_flag.sv
module itmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  output logic flag,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= fire;
      if (fire)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !flag); // R7

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !fire) |=> !irq); // R7

  AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !fire) |=> !flag); // R5

endmodule

// File: rtl/interval_alarm_timer.sv
module interval_alarm_timer
  import itmr_pkg::*;
#(
  parameter int CNT_W = TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_frac,
  input  logic             stb_sec,
  input  logic             stb_min,
  input  logic             stb_hour,
  input  logic [1:0]       base_sel,
  input  logic             one_shot,
  input  logic             tmr_en,
  input  logic             rtc_en,
  input  logic [CNT_W-1:0] interval,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] tick_count,
  output logic             alarm_flag,
  output logic             alarm_irq
);

  logic [NUM_BASES-1:0] strobes;
  logic                 sel_tick;
  logic                 alarm_fire;
  logic                 shot_done;

  assign strobes[BASE_FRAC] = stb_frac;
  assign strobes[BASE_SEC]  = stb_sec;
  assign strobes[BASE_MIN]  = stb_min;
  assign strobes[BASE_HOUR] = stb_hour;

  itmr_base_mux #(.N_BASE(NUM_BASES), .S_W(SEL_W)) u_mux (
    .strobes (strobes),
    .sel     (base_sel),
    .tick    (sel_tick)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sel_tick),
    .tmr_en   (tmr_en),
    .rtc_en   (rtc_en),
    .one_shot (one_shot),
    .interval (interval),
    .count    (tick_count),
    .fire     (alarm_fire),
    .stopped  (shot_done)
  );

  itmr_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (alarm_fire),
    .clr   (flag_clr),
    .flag  (alarm_flag),
    .irq   (alarm_irq)
  );

  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alarm_flag); // R7

  AST_NO_FIRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtc_en || !tmr_en) |-> !alarm_fire); // R4

endmodule

// File: tb/test_interval_alarm_timer.sv
module test_interval_alarm_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] stb = '0;
  logic [1:0] base_sel = '0;
  logic       one_shot = 1'b0;
  logic       tmr_en = 1'b0;
  logic       rtc_en = 1'b1;
  logic [7:0] interval = '0;
  logic       flag_clr = 1'b0;
  logic [7:0] tick_count;
  logic       alarm_flag;
  logic       alarm_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic exp_flag = 1'b0;

  always #4 clk = ~clk;

  interval_alarm_timer i_interval_alarm_timer (
    .clk(clk), .rst_n(rst_n),
    .stb_frac(stb[0]), .stb_sec(stb[1]), .stb_min(stb[2]), .stb_hour(stb[3]),
    .base_sel(base_sel), .one_shot(one_shot), .tmr_en(tmr_en), .rtc_en(rtc_en),
    .interval(interval), .flag_clr(flag_clr),
    .tick_count(tick_count), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle of stimulus, outputs sampled at the following falling edge
  task automatic step(input logic [3:0] s, input logic clr);
    stb = s; flag_clr = clr;
    @(negedge clk);
    stb = '0; flag_clr = 1'b0;
  endtask

  task automatic rearm();
    tmr_en = 1'b0;
    step('0, 1'b1);
    exp_flag = 1'b0;
    chk("R3 count cleared", tick_count, 0);
    tmr_en = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int ivs[5] = '{1, 2, 3, 5, 0};
    @(negedge clk);
    chk("R8 count", tick_count, 0);
    chk("R8 flag", alarm_flag, 0);
    chk("R8 irq", alarm_irq, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int b = 0; b < 4; b++) begin
      for (int m = 0; m < 2; m++) begin
        for (int v = 0; v < 5; v++) begin
          int span;
          base_sel = 2'(b); one_shot = m[0]; interval = 8'(ivs[v]);
          span = (ivs[v] == 0) ? 256 : ivs[v];
          rearm();
          // R1: other bases ignored
          step(4'hF & ~(4'b1 << b), 1'b0);
          chk("R1 unselected strobe", tick_count, 0);
          chk("R1 unselected irq", alarm_irq, 0);
          for (int k = 1; k <= 2 * span; k++) begin
            logic clr, hit;
            int ec;
            clr = (k % 3 == 0);
            if (m == 0) begin
              hit = (k % span == 0);
              ec = k % span;
            end else begin
              hit = (k == span);
              ec = (k < span) ? k : 0;
            end
            exp_flag = hit ? 1'b1 : (clr ? 1'b0 : exp_flag);
            step(4'b1 << b, clr);
            chk(m ? "R6 one-shot count" : "R2/R5 count", tick_count, ec);
            chk("R7 flag", alarm_flag, exp_flag);
            chk("R7 irq", alarm_irq, hit);
          end
          @(negedge clk);
          chk("R7 irq single cycle", alarm_irq, 0);
        end
      end
    end

    // R4: rtc disabled holds count
    base_sel = 2'd1; one_shot = 1'b0; interval = 8'd4;
    rearm();
    step(4'b0010, 1'b0);
    step(4'b0010, 1'b0);
    rtc_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      step(4'b0010, 1'b0);
      chk("R4 hold count", tick_count, 2);
      chk("R4 no alarm", alarm_irq, 0);
    end
    rtc_en = 1'b1;
    step(4'b0010, 1'b0);
    chk("R4 resume count", tick_count, 3);
    // R3: disable mid-count clears and ignores strobes
    tmr_en = 1'b0;
    step(4'b0010, 1'b0);
    chk("R3 cleared mid-count", tick_count, 0);
    step(4'b0010, 1'b0);
    chk("R3 no count while off", tick_count, 0);
    // R5: interval 255 fires at 255
    tmr_en = 1'b1; interval = 8'd255; base_sel = 2'd0;
    step('0, 1'b1);
    for (int k = 1; k <= 255; k++) begin
      step(4'b0001, 1'b0);
      if (k == 254) chk("R5 count 254", tick_count, 254);
    end
    chk("R5 wrap at 255", tick_count, 0);
    chk("R5 flag at 255", alarm_flag, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule